// File: doc/BRIEF.md
# Interrupt Mask and Priority Register File with Change Events

This block holds a small set of interrupt mask registers and interrupt priority registers behind a memory-mapped write/read port. Each register can be reached through a pair of aliases, one that sets bits and one that clears bits. A priority register may instead have one direct address, where a write replaces the whole value. Only the low 29 address bits take part in the address compare, so the upper three bits can carry any value.

Every register is divided into fields. Mask registers have 1-bit fields and priority registers have 4-bit fields. Each field is tied to an interrupt identifier. After a write, the block compares the old and new value of every field. For each field that changed, it sends an enable or disable event for the tied identifier. An identifier that stands for a group hands the event on to each member of its chain. The pending logic that consumes these events lies outside this block.

The chain is walked one identifier per clock. While a walk is running, the write port reports not-ready, and any write presented during that time is dropped.

Top module: `intc_setclr_regs`

## Requirements
- R1: Address compare uses bits 28:0 only; register r (0,1 mask; 2,3 priority) has its set alias at BASE_ADDR+16*r and its clear alias 4 bytes above, except register 3, which is direct and answers only at BASE_ADDR+16*3; a write to any other address changes nothing, and a read of it returns 0.
- R2: A write through a set alias ORs the data into the register.
- R3: A write through a clear alias ANDs the register with the inverted data.
- R4: A write to the direct priority register replaces its value with the data.
- R5: A read at either alias of a register returns the stored value in the same cycle.
- R6: Mask register r bit f is tied to identifier 8*r+f. Priority register j field f (bits 4f+3:4f) is tied to identifier 16+2*(j-2)+f. A field whose value did not change gives no event. A changed field gives an event whose enable flag is 1 when the new field value is non-zero and 0 otherwise.
- R7: Changed fields of one write are handled from the most significant field down to the least significant, and their events leave in that order.
- R8: Identifier 0 gives no event. Identifiers 12 and 13 are reserved by default (12 needs no enables; 13 has no vector and no link) and give no event.
- R9: An identifier without a vector that has a link passes its event down its chain, and each vectored member emits the same enable flag in chain order. The default chains are 7→20→21→22 and 17→23→24. Identifier 5 has a vector and a link to 25; when its own field changes, only 5 emits.
- R10: From an accepted write that changes a field, wr_ready stays low until the last event of that write has left. A write presented while wr_ready is low leaves the registers unchanged and gives no event.
- R11: After reset, all registers read 0, wr_ready is high and no event is signalled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | 32 | Byte address for both write and read |
| wr_en | input | 1 | Write strobe, taken when wr_ready is high |
| wr_data | input | 8 | Write data |
| wr_ready | output | 1 | High when no event walk is running |
| rd_data | output | 8 | Value of the addressed register, 0 on a miss |
| evt_valid | output | 1 | An enable/disable event is presented this cycle |
| evt_id | output | 5 | Identifier the event targets |
| evt_enable | output | 1 | 1 for enable, 0 for disable |

## Verification
The hardest case to reach from the ports is a write that arrives while a group chain is still being walked. The write must be dropped, and the walk must neither be cut short nor pick up a stray event. A directed sequence starts a three-member chain walk. It then holds a write to another register on the bus during the walk, and afterwards reads that register back and compares the complete event list. Random writes across both aliases, the direct register, and junk upper address bits are checked against a bench model that walks the chain tables as the requirements list them. The random writes also exercise multi-field changes, so the most-significant-first ordering is checked under many patterns.

// File: rtl/intc_rf_pkg.sv
package intc_rf_pkg;

    localparam int DEF_NMASK   = 2;
    localparam int DEF_NPRIO   = 2;
    localparam int DEF_REG_W   = 8;
    localparam int DEF_PRIO_FW = 4;
    localparam int DEF_NID     = 32;
    localparam int DEF_ID_W    = 5;
    localparam int DEF_NPF     = DEF_REG_W / DEF_PRIO_FW;
    localparam int DEF_NSLOT   = DEF_NMASK * DEF_REG_W + DEF_NPRIO * DEF_NPF;

    typedef enum logic [1:0] {
        WM_NONE   = 2'd0,
        WM_SET    = 2'd1,
        WM_CLR    = 2'd2,
        WM_DIRECT = 2'd3
    } wmode_e;

    // Field slot s is tied to identifier s by default.
    function automatic logic [DEF_NSLOT*DEF_ID_W-1:0] def_field_ids();
        logic [DEF_NSLOT*DEF_ID_W-1:0] r;
        r = '0;
        for (int s = 0; s < DEF_NSLOT; s++) begin
            r[s*DEF_ID_W +: DEF_ID_W] = DEF_ID_W'(s);
        end
        return r;
    endfunction

    function automatic logic [DEF_NID-1:0] def_has_vec();
        logic [DEF_NID-1:0] r;
        r     = '1;
        r[0]  = 1'b0;
        r[7]  = 1'b0;
        r[13] = 1'b0;
        r[17] = 1'b0;
        return r;
    endfunction

    function automatic logic [DEF_NID-1:0] def_en_req();
        logic [DEF_NID-1:0] r;
        r     = '1;
        r[0]  = 1'b0;
        r[12] = 1'b0;
        r[13] = 1'b0;
        return r;
    endfunction

    function automatic logic [DEF_NID*DEF_ID_W-1:0] def_next_id();
        logic [DEF_NID*DEF_ID_W-1:0] r;
        r = '0;
        r[7*DEF_ID_W  +: DEF_ID_W] = DEF_ID_W'(20);
        r[20*DEF_ID_W +: DEF_ID_W] = DEF_ID_W'(21);
        r[21*DEF_ID_W +: DEF_ID_W] = DEF_ID_W'(22);
        r[17*DEF_ID_W +: DEF_ID_W] = DEF_ID_W'(23);
        r[23*DEF_ID_W +: DEF_ID_W] = DEF_ID_W'(24);
        r[5*DEF_ID_W  +: DEF_ID_W] = DEF_ID_W'(25);
        return r;
    endfunction

endpackage

// File: rtl/intc_rf_addr_dec.sv
module intc_rf_addr_dec
    import intc_rf_pkg::*;
#(
    parameter int              NMASK       = 2,
    parameter int              NPRIO       = 2,
    parameter logic [NPRIO-1:0] PRIO_DIRECT = 2'b10,
    parameter logic [28:0]     BASE_ADDR   = 29'h0080_0000,
    localparam int             NREG        = NMASK + NPRIO,
    localparam int             IDX_W       = (NREG > 1) ? $clog2(NREG) : 1
) (
    input  logic [31:0]      addr,
    output logic             hit,
    output logic [IDX_W-1:0] idx,
    output wmode_e           mode
);

    localparam int STRIDE  = 16;
    localparam int CLR_OFS = 4;
    localparam logic [31:0] LOW29 = 32'h1FFF_FFFF;

    logic [NREG-1:0] set_m;
    logic [NREG-1:0] clr_m;
    logic [NREG-1:0] dual_v;
    logic [31:0]     addr_l;

    assign addr_l = addr & LOW29;

    for (genvar r = 0; r < NREG; r++) begin : g_reg
        localparam logic [28:0] SET_A = BASE_ADDR + 29'(r * STRIDE);
        localparam logic [28:0] CLR_A = SET_A + 29'(CLR_OFS);
        if (r < NMASK) begin : g_mask
            assign dual_v[r] = 1'b1;
        end else begin : g_prio
            assign dual_v[r] = !PRIO_DIRECT[r-NMASK];
        end
        assign set_m[r] = (addr_l == {3'b000, SET_A});
        assign clr_m[r] = dual_v[r] && (addr_l == {3'b000, CLR_A});
    end

    always_comb begin
        hit  = 1'b0;
        idx  = '0;
        mode = WM_NONE;
        for (int r = 0; r < NREG; r++) begin
            if (set_m[r]) begin
                hit  = 1'b1;
                idx  = IDX_W'(r);
                mode = dual_v[r] ? WM_SET : WM_DIRECT;
            end else if (clr_m[r]) begin
                hit  = 1'b1;
                idx  = IDX_W'(r);
                mode = WM_CLR;
            end
        end
    end

endmodule

// File: rtl/intc_rf_field_diff.sv
module intc_rf_field_diff
    import intc_rf_pkg::*;
#(
    parameter int  REG_W   = 8,
    parameter int  PRIO_FW = 4,
    localparam int NPF     = REG_W / PRIO_FW
) (
    input  logic [REG_W-1:0] old_val,
    input  logic [REG_W-1:0] wdata,
    input  wmode_e           mode,
    input  logic             is_prio,
    output logic [REG_W-1:0] new_val,
    output logic [REG_W-1:0] chg,
    output logic [REG_W-1:0] nz
);

    logic [REG_W-1:0] m_chg;
    logic [REG_W-1:0] m_nz;
    logic [NPF-1:0]   p_chg;
    logic [NPF-1:0]   p_nz;

    always_comb begin
        unique case (mode)
            WM_SET:    new_val = old_val | wdata;
            WM_CLR:    new_val = old_val & ~wdata;
            WM_DIRECT: new_val = wdata;
            default:   new_val = old_val;
        endcase
    end

    for (genvar f = 0; f < REG_W; f++) begin : g_bit
        assign m_chg[f] = old_val[f] ^ new_val[f];
        assign m_nz[f]  = new_val[f];
    end

    for (genvar f = 0; f < NPF; f++) begin : g_fld
        assign p_chg[f] = old_val[f*PRIO_FW +: PRIO_FW] != new_val[f*PRIO_FW +: PRIO_FW];
        assign p_nz[f]  = |new_val[f*PRIO_FW +: PRIO_FW];
    end

    assign chg = is_prio ? REG_W'(p_chg) : m_chg;
    assign nz  = is_prio ? REG_W'(p_nz)  : m_nz;

endmodule

// File: rtl/intc_rf_chain_walker.sv
module intc_rf_chain_walker #(
    parameter int                    REG_W    = 8,
    parameter int                    NID      = 32,
    parameter int                    ID_W     = 5,
    parameter int                    NSLOT    = 20,
    parameter int                    SLOT_W   = 5,
    parameter logic [NSLOT*ID_W-1:0] FIELD_ID = '0,
    parameter logic [NID-1:0]        HAS_VEC  = '0,
    parameter logic [NID-1:0]        EN_REQ   = '0,
    parameter logic [NID*ID_W-1:0]   NEXT_ID  = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [REG_W-1:0]  start_chg,
    input  logic [REG_W-1:0]  start_nz,
    input  logic [SLOT_W-1:0] start_base,
    output logic              busy,
    output logic              evt_valid,
    output logic [ID_W-1:0]   evt_id,
    output logic              evt_en
);

    localparam int FI_W = (REG_W > 1) ? $clog2(REG_W) : 1;

    typedef struct packed {
        logic [REG_W-1:0]  pend;
        logic [REG_W-1:0]  nz;
        logic [SLOT_W-1:0] base;
        logic              walking;
        logic [ID_W-1:0]   cur_id;
        logic              cur_en;
        logic              evt_valid;
        logic [ID_W-1:0]   evt_id;
        logic              evt_en;
    } wstate_t;

    wstate_t         s_d, s_q;
    logic            act;
    logic            grp;
    logic            ven;
    logic            found;
    logic            rsv;
    logic [ID_W-1:0] vid;
    logic [ID_W-1:0] nxt;
    logic [FI_W-1:0] top;
    int              slot_i;

    always_comb begin
        s_d           = s_q;
        s_d.evt_valid = 1'b0;
        act           = 1'b0;
        grp           = 1'b0;
        ven           = 1'b0;
        vid           = '0;
        nxt           = '0;
        rsv           = 1'b1;
        found         = 1'b0;
        top           = '0;
        slot_i        = 0;

        // highest pending field wins
        for (int f = 0; f < REG_W; f++) begin
            if (s_q.pend[f]) begin
                top   = FI_W'(f);
                found = 1'b1;
            end
        end

        if (start) begin
            s_d.pend    = start_chg;
            s_d.nz      = start_nz;
            s_d.base    = start_base;
            s_d.walking = 1'b0;
        end else if (s_q.walking) begin
            act = 1'b1;
            grp = 1'b1;
            vid = s_q.cur_id;
            ven = s_q.cur_en;
        end else if (found) begin
            act    = 1'b1;
            slot_i = int'(s_q.base) + int'(top);
            vid    = FIELD_ID[slot_i*ID_W +: ID_W];
            ven    = s_q.nz[top];
            s_d.pend[top] = 1'b0;
        end

        if (act) begin
            nxt         = NEXT_ID[int'(vid)*ID_W +: ID_W];
            rsv         = (vid == '0) || ((nxt == '0) && (!EN_REQ[vid] || !HAS_VEC[vid]));
            s_d.walking = 1'b0;
            if (!rsv) begin
                if (HAS_VEC[vid]) begin
                    s_d.evt_valid = 1'b1;
                    s_d.evt_id    = vid;
                    s_d.evt_en    = ven;
                end
                if ((grp || !HAS_VEC[vid]) && (nxt != '0)) begin
                    s_d.walking = 1'b1;
                    s_d.cur_id  = nxt;
                    s_d.cur_en  = ven;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign busy      = s_q.walking | (|s_q.pend);
    assign evt_valid = s_q.evt_valid;
    assign evt_id    = s_q.evt_id;
    assign evt_en    = s_q.evt_en;

    // R8
    evt_id_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        evt_valid |-> (evt_id != '0));

    // R9
    evt_vectored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        evt_valid |-> HAS_VEC[evt_id]);

    // R10
    evt_in_walk_chk: assert property (@(posedge clk) disable iff (!rst_n)
        evt_valid |-> $past(busy));

endmodule

// File: rtl/intc_setclr_regs.sv
module intc_setclr_regs
    import intc_rf_pkg::*;
#(
    parameter int                    NMASK       = DEF_NMASK,
    parameter int                    NPRIO       = DEF_NPRIO,
    parameter int                    REG_W       = DEF_REG_W,
    parameter int                    PRIO_FW     = DEF_PRIO_FW,
    parameter int                    NID         = DEF_NID,
    parameter int                    ID_W        = DEF_ID_W,
    parameter logic [NPRIO-1:0]      PRIO_DIRECT = 2'b10,
    parameter logic [28:0]           BASE_ADDR   = 29'h0080_0000,
    localparam int                   NREG        = NMASK + NPRIO,
    localparam int                   NPF         = REG_W / PRIO_FW,
    localparam int                   NSLOT       = NMASK * REG_W + NPRIO * NPF,
    localparam int                   SLOT_W      = $clog2(NSLOT + 1),
    localparam int                   IDX_W       = (NREG > 1) ? $clog2(NREG) : 1,
    parameter logic [NSLOT*ID_W-1:0] FIELD_ID    = def_field_ids(),
    parameter logic [NID-1:0]        HAS_VEC     = def_has_vec(),
    parameter logic [NID-1:0]        EN_REQ      = def_en_req(),
    parameter logic [NID*ID_W-1:0]   NEXT_ID     = def_next_id()
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [31:0]      bus_addr,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    output logic             wr_ready,
    output logic [REG_W-1:0] rd_data,
    output logic             evt_valid,
    output logic [ID_W-1:0]  evt_id,
    output logic             evt_enable
);

    typedef struct packed {
        logic [NREG-1:0][REG_W-1:0] regs;
    } rf_state_t;

    rf_state_t         st_d, st_q;
    logic              dec_hit;
    logic [IDX_W-1:0]  dec_idx;
    wmode_e            dec_mode;
    logic              is_prio;
    logic              busy;
    logic              start;
    logic [REG_W-1:0]  old_val;
    logic [REG_W-1:0]  new_val;
    logic [REG_W-1:0]  chg;
    logic [REG_W-1:0]  nz;
    logic [SLOT_W-1:0] slot_base;

    intc_rf_addr_dec #(
        .NMASK      (NMASK),
        .NPRIO      (NPRIO),
        .PRIO_DIRECT(PRIO_DIRECT),
        .BASE_ADDR  (BASE_ADDR)
    ) addr_dec_i (
        .addr(bus_addr),
        .hit (dec_hit),
        .idx (dec_idx),
        .mode(dec_mode)
    );

    assign old_val = st_q.regs[dec_idx];
    assign is_prio = int'(dec_idx) >= NMASK;

    intc_rf_field_diff #(
        .REG_W  (REG_W),
        .PRIO_FW(PRIO_FW)
    ) field_diff_i (
        .old_val(old_val),
        .wdata  (wr_data),
        .mode   (dec_mode),
        .is_prio(is_prio),
        .new_val(new_val),
        .chg    (chg),
        .nz     (nz)
    );

    always_comb begin
        if (is_prio) begin
            slot_base = SLOT_W'(NMASK * REG_W + (int'(dec_idx) - NMASK) * NPF);
        end else begin
            slot_base = SLOT_W'(int'(dec_idx) * REG_W);
        end
    end

    assign start = wr_en && !busy && dec_hit;

    always_comb begin
        st_d = st_q;
        if (start) begin
            st_d.regs[dec_idx] = new_val;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    intc_rf_chain_walker #(
        .REG_W   (REG_W),
        .NID     (NID),
        .ID_W    (ID_W),
        .NSLOT   (NSLOT),
        .SLOT_W  (SLOT_W),
        .FIELD_ID(FIELD_ID),
        .HAS_VEC (HAS_VEC),
        .EN_REQ  (EN_REQ),
        .NEXT_ID (NEXT_ID)
    ) walker_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .start_chg (chg),
        .start_nz  (nz),
        .start_base(slot_base),
        .busy      (busy),
        .evt_valid (evt_valid),
        .evt_id    (evt_id),
        .evt_en    (evt_enable)
    );

    assign wr_ready = !busy;
    assign rd_data  = dec_hit ? st_q.regs[dec_idx] : '0;

    // R2
    set_alias_or_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && dec_mode == WM_SET) |=>
            ((st_q.regs[$past(dec_idx)] & $past(wr_data)) == $past(wr_data)));

    // R3
    clr_alias_and_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && dec_mode == WM_CLR) |=>
            ((st_q.regs[$past(dec_idx)] & $past(wr_data)) == '0));

    // R4
    direct_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && dec_mode == WM_DIRECT) |=>
            (st_q.regs[$past(dec_idx)] == $past(wr_data)));

    // R10
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_ready) |=> $stable(st_q.regs));

endmodule

// File: tb/intc_setclr_regs_tb.sv
`timescale 1ns/1ps
module intc_setclr_regs_tb_top;

    localparam logic [28:0] BASE = 29'h0080_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] bus_addr = '0;
    logic        wr_en = 1'b0;
    logic [7:0]  wr_data = '0;
    logic        wr_ready;
    logic [7:0]  rd_data;
    logic        evt_valid;
    logic [4:0]  evt_id;
    logic        evt_enable;

    int checks = 0;
    int errors = 0;

    bit          hv[32];
    bit          er[32];
    int          nx[32];
    logic [7:0]  mreg[4];
    logic [5:0]  exp_q[$];
    logic [5:0]  act_q[$];

    always #4 clk = ~clk;

    intc_setclr_regs dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .wr_ready  (wr_ready),
        .rd_data   (rd_data),
        .evt_valid (evt_valid),
        .evt_id    (evt_id),
        .evt_enable(evt_enable)
    );

    function automatic logic [31:0] set_a(int r);
        return {3'b000, BASE + 29'(16 * r)};
    endfunction

    function automatic logic [31:0] clr_a(int r);
        return {3'b000, BASE + 29'(16 * r + 4)};
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // address decode from R1: returns mode 1 set, 2 clear, 3 direct
    function automatic bit dec(logic [31:0] a, output int r, output int m);
        logic [28:0] a29;
        a29 = a[28:0];
        r = 0;
        m = 0;
        for (int i = 0; i < 4; i++) begin
            if (a29 == BASE + 29'(16 * i)) begin
                r = i; m = (i == 3) ? 3 : 1; return 1'b1;
            end
            if (i != 3 && a29 == BASE + 29'(16 * i + 4)) begin
                r = i; m = 2; return 1'b1;
            end
        end
        return 1'b0;
    endfunction

    // R8 / R9 event rules
    task automatic visit(int id, bit en);
        int  cur;
        bit  grp;
        cur = id;
        grp = 1'b0;
        for (int guard = 0; guard < 40; guard++) begin
            if (cur == 0) return;
            if (nx[cur] == 0 && (!er[cur] || !hv[cur])) return;
            if (hv[cur]) exp_q.push_back({en, 5'(cur)});
            if ((grp || !hv[cur]) && nx[cur] != 0) begin
                cur = nx[cur];
                grp = 1'b1;
            end else begin
                return;
            end
        end
    endtask

    // R2 R3 R4 R6 R7 model
    task automatic model_write(logic [31:0] a, logic [7:0] d);
        int r, m;
        logic [7:0] o, n;
        if (!dec(a, r, m)) return;
        o = mreg[r];
        case (m)
            1: n = o | d;
            2: n = o & ~d;
            default: n = d;
        endcase
        if (r < 2) begin
            for (int f = 7; f >= 0; f--)
                if (o[f] != n[f]) visit(8 * r + f, n[f]);
        end else begin
            for (int f = 1; f >= 0; f--)
                if (o[4*f +: 4] != n[4*f +: 4]) visit(16 + 2 * (r - 2) + f, |n[4*f +: 4]);
        end
        mreg[r] = n;
    endtask

    task automatic grab();
        if (evt_valid) act_q.push_back({evt_enable, evt_id});
    endtask

    task automatic wait_idle();
        int wd;
        wd = 0;
        while (!wr_ready && wd < 1000) begin
            @(negedge clk);
            grab();
            wd++;
        end
        if (wd >= 1000) chk("R10 walk end", 32'(wr_ready), 32'd1);
    endtask

    task automatic cmp_events(string req);
        chk({req, " event count"}, 32'(act_q.size()), 32'(exp_q.size()));
        if (act_q.size() == exp_q.size())
            for (int i = 0; i < act_q.size(); i++)
                chk({req, " event"}, 32'(act_q[i]), 32'(exp_q[i]));
        act_q.delete();
        exp_q.delete();
    endtask

    task automatic do_write(logic [31:0] a, logic [7:0] d);
        model_write(a, d);
        @(negedge clk);
        bus_addr = a;
        wr_data  = d;
        wr_en    = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
        grab();
        wait_idle();
    endtask

    task automatic rd(logic [31:0] a, output logic [7:0] v);
        @(negedge clk);
        wr_en    = 1'b0;
        bus_addr = a;
        #1;
        v = rd_data;
    endtask

    task automatic check_all_regs(string req);
        logic [7:0] v;
        for (int r = 0; r < 4; r++) begin
            rd(set_a(r), v);
            chk(req, 32'(v), 32'(mreg[r]));
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] v;
        int seed;
        for (int i = 0; i < 32; i++) begin
            hv[i] = 1'b1; er[i] = 1'b1; nx[i] = 0;
        end
        hv[0] = 0; hv[7] = 0; hv[13] = 0; hv[17] = 0;
        er[0] = 0; er[12] = 0; er[13] = 0;
        nx[7] = 20; nx[20] = 21; nx[21] = 22;
        nx[17] = 23; nx[23] = 24; nx[5] = 25;
        for (int r = 0; r < 4; r++) mreg[r] = '0;
        seed = $urandom(32'd20240611);

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11 reset state
        chk("R11 wr_ready", 32'(wr_ready), 32'd1);
        chk("R11 evt_valid", 32'(evt_valid), 32'd0);
        check_all_regs("R11 reg zero");

        // R9 group 7 chain; R8 id 0 silent; R7 order
        do_write(set_a(0), 8'h81);
        cmp_events("R9 group 7");
        // R9 id 5 has vector and link: only itself
        do_write(set_a(0), 8'h20);
        cmp_events("R9 id 5 alone");
        // R8 reserved ids 12, 13
        do_write(set_a(1), 8'h38);
        cmp_events("R8 reserved");
        // R3 clear alias
        do_write(clr_a(0), 8'h81);
        cmp_events("R3 clear events");
        rd(clr_a(0), v);
        chk("R3 R5 clear alias readback", 32'(v), 32'h20);
        // R7 priority fields high first, R9 group 17
        do_write(set_a(2), 8'h31);
        cmp_events("R7 prio order");
        // R4 direct register, R6 nonzero-to-nonzero change
        do_write(set_a(3), 8'h50);
        cmp_events("R4 direct");
        do_write(set_a(3), 8'h70);
        cmp_events("R6 field stays nonzero");
        do_write(set_a(3), 8'h07);
        cmp_events("R6 disable and enable");
        rd(set_a(3), v);
        chk("R4 direct value", 32'(v), 32'h07);
        // R1 upper address bits ignored
        do_write({3'b101, set_a(1)[28:0]}, 8'h01);
        cmp_events("R1 upper bits");
        // R1 unmatched addresses
        do_write({3'b000, BASE + 29'h8}, 8'hFF);
        cmp_events("R1 miss");
        do_write(clr_a(3), 8'hFF);
        cmp_events("R1 direct has no clear alias");
        rd(clr_a(3), v);
        chk("R1 miss reads zero", 32'(v), 32'd0);
        check_all_regs("R1 regs unchanged");

        // R10 write during walk is dropped
        model_write(set_a(0), 8'h80);
        @(negedge clk);
        bus_addr = set_a(0);
        wr_data  = 8'h80;
        wr_en    = 1'b1;
        @(negedge clk);
        grab();
        chk("R10 wr_ready low in walk", 32'(wr_ready), 32'd0);
        bus_addr = set_a(1);
        wr_data  = 8'hFF;
        @(negedge clk);
        grab();
        wr_en = 1'b0;
        wait_idle();
        cmp_events("R10 dropped write");
        check_all_regs("R10 regs after dropped write");

        // random traffic
        for (int n = 0; n < 400; n++) begin
            int r, al;
            logic [31:0] a;
            logic [7:0] d;
            r  = int'($urandom % 4);
            al = int'($urandom % 2);
            a  = (al == 1) ? clr_a(r) : set_a(r);
            a[31:29] = 3'($urandom % 8);
            if ($urandom % 8 == 0) a = a + 32'd8;
            d  = 8'($urandom % 256);
            do_write(a, d);
            cmp_events("R6 R7 random");
            rd(set_a(r), v);
            chk("R5 set alias read", 32'(v), 32'(mreg[r]));
            if (r != 3) begin
                rd(clr_a(r), v);
                chk("R5 clear alias read", 32'(v), 32'(mreg[r]));
            end
        end
        check_all_regs("R2 R3 final");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule